// File: doc/BRIEF.md
# Multi-Channel Clock Divider Synchronizer

This block drives a bank of programmable clock dividers from one input clock and lines their outputs up on demand. Each divider toggles its output every `div + 1` input cycles and starts counting from a programmable phase offset. A sync sequence forces every channel that is not excluded into a fixed static state: output low, counter loaded with its phase offset. When the sync is released, all of those channels resume on the same input clock edge. Their edges then coincide, or stay apart by exactly their phase offsets.

A sync can be requested from several places, and all of them are merged into one request:
- an active-low external pin;
- a calibration-busy level;
- an active-low power-down pin;
- soft-reset and distribution-power-down levels;
- a software sync bit, which sits behind a shadow register and only takes effect on an update strobe.

Chip reset also starts a sync. The merged request passes through a two-flop synchronizer into the divider clock domain. A fixed countdown then releases all channels together. A new request that arrives during the countdown cancels it and returns the channels to the held state.

Top module: `clkdiv_sync_top`

## Requirements
- R1: A channel whose exclude bit is 1 ignores every sync source and keeps toggling its output every `div + 1` input cycles.
- R2: While a sync is in effect, every channel that is not excluded holds its output at 0. Its counter is preset to its phase offset.
- R3: After release, a non-excluded channel with phase offset `p` and divide value `d` first drives its output high on input clock edge 14 + p. Edges are counted with edge 1 being the first rising clock edge after the request deasserts. The output then toggles every `d + 1` cycles, so channels with equal phase offsets rise on the same edge.
- R4: The external sync pin is active low. The channels stay held for as long as the pin is low, and the release timing of R3 counts from the pin's rising edge.
- R5: A high calibration-busy level holds the channels like the sync pin. Its falling edge releases them with the R3 timing.
- R6: A low power-down pin, a high soft-reset level and a high distribution-power-down level each hold the channels. Each releases them with the R3 timing when it returns to its idle level.
- R7: The software sync bit acts only through its shadow. A write (`sh_we_i` = 1, value `sh_din_i`) changes nothing at the outputs until `update_i` copies the shadow into the active bit. An update that sets the bit holds the channels. An update that clears it releases them, with the first high output on edge 15 + p counted from the edge that samples the update strobe.
- R8: During reset every output is 0. Release from reset starts a sync, so a non-excluded channel first goes high on edge 14 + p after reset is released.
- R9: A new request during the release countdown cancels it. The channels return to the held state, and timing restarts from the later release with the R3 timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Divider input clock |
| rst_n_i | input | 1 | Asynchronous active-low chip reset |
| sync_n_i | input | 1 | External sync request, active low, asynchronous |
| pwrdn_n_i | input | 1 | Chip power-down, active low |
| cal_busy_i | input | 1 | Calibration in progress; requests sync while high |
| soft_rst_i | input | 1 | Soft-reset level; requests sync while high |
| dist_pd_i | input | 1 | Distribution power-down level; requests sync while high |
| sh_we_i | input | 1 | Write strobe for the shadow software sync bit |
| sh_din_i | input | 1 | Value written to the shadow software sync bit |
| update_i | input | 1 | Copies shadow registers into the active registers |
| excl_i | input | NCH | Per-channel exclude from sync |
| div_i | input | NCH*DIVW | Per-channel divide value; the output toggles every value+1 cycles |
| phase_i | input | NCH*DIVW | Per-channel phase offset, in input cycles |
| clk_o | output | NCH | Divided clock outputs |

## Verification
The assertions assume that the divide, phase and exclude settings stay constant from the start of a sync until the restart pulse. They also assume that the asynchronous sources meet the two-flop synchronizer and do not toggle within a cycle. The bench therefore reprograms dividers only while the channels are running, before it raises a request. It drives every request source and strobe on the falling clock edge, so each change is captured by one known rising edge. That fixed capture edge also makes the R3 edge count exact rather than 14-or-15.

// File: rtl/clkdiv_sync_pkg.sv
package clkdiv_sync_pkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_COUNT = 2'd1,
    ST_RUN   = 2'd2
  } rel_state_t;

  // Countdown length so that the first output edge of a zero-phase channel
  // lands on edge `lat` after the request drops: stages for the
  // synchronizer, one for HOLD->COUNT, one for the RUN edge.
  function automatic int release_cycles(input int lat, input int stages);
    return lat - stages - 2;
  endfunction

  // Divider counter step: reload on zero, else count down.
  function automatic logic [31:0] next_count(input logic [31:0] cnt,
                                             input logic [31:0] div);
    return (cnt == 32'd0) ? div : cnt - 32'd1;
  endfunction

endpackage

// File: rtl/clkdiv_sync_req.sv
module clkdiv_sync_req #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic sync_n_i,
  input  logic pwrdn_n_i,
  input  logic cal_busy_i,
  input  logic soft_rst_i,
  input  logic dist_pd_i,
  input  logic sh_we_i,
  input  logic sh_din_i,
  input  logic update_i,
  output logic req_o
);

  logic soft_shadow_q;
  logic soft_act_q;
  logic raw_req;
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      soft_shadow_q <= 1'b0;
      soft_act_q    <= 1'b0;
    end else begin
      if (sh_we_i)  soft_shadow_q <= sh_din_i;
      if (update_i) soft_act_q    <= soft_shadow_q;
    end
  end

  assign raw_req = ~sync_n_i | ~pwrdn_n_i | cal_busy_i |
                   soft_rst_i | dist_pd_i | soft_act_q;

  // Reset value of 1 makes release from reset a sync event.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '1;
    else          sync_q <= {sync_q[SYNC_STAGES-2:0], raw_req};
  end

  assign req_o = sync_q[SYNC_STAGES-1];

  // R7: the active soft sync bit moves only on an update strobe
  assert_soft_update_only_R7: assert property (
    @(posedge clk_i) disable iff (!rst_n_i)
    !update_i |=> $stable(soft_act_q));

endmodule

// File: rtl/clkdiv_sync_release.sv
module clkdiv_sync_release
  import clkdiv_sync_pkg::*;
#(
  parameter int LATENCY     = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic req_i,
  output logic hold_o,
  output logic restart_o
);

  localparam int RC = release_cycles(LATENCY, SYNC_STAGES);
  localparam int CW = $clog2(RC + 1);
  localparam logic [CW-1:0] LAST = CW'(RC - 1);

  rel_state_t    state_q;
  logic [CW-1:0] cnt_q;
  logic          cnt_done;

  assign cnt_done  = (cnt_q == LAST);
  assign restart_o = (state_q == ST_COUNT) && cnt_done && !req_i;
  assign hold_o    = (state_q != ST_RUN);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
    end else if (req_i) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_HOLD: begin
          state_q <= ST_COUNT;
          cnt_q   <= '0;
        end
        ST_COUNT: begin
          if (cnt_done) state_q <= ST_RUN;
          else          cnt_q   <= cnt_q + CW'(1);
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  // R4: any synchronized request holds the channels on the next cycle
  assert_req_holds_R4: assert property (
    @(posedge clk_i) disable iff (!rst_n_i)
    req_i |=> hold_o);

  // R9: a request during the countdown aborts it without a restart
  assert_abort_countdown_R9: assert property (
    @(posedge clk_i) disable iff (!rst_n_i)
    (state_q == ST_COUNT && req_i) |=> (state_q == ST_HOLD && !restart_o));

  // R3: restart is a single pulse followed by running
  assert_restart_single_R3: assert property (
    @(posedge clk_i) disable iff (!rst_n_i)
    restart_o |=> (!restart_o && !hold_o));

  // R3: the countdown never runs past its end
  assert_count_bound_R3: assert property (
    @(posedge clk_i) disable iff (!rst_n_i)
    (state_q == ST_COUNT) |-> (cnt_q <= LAST));

endmodule

// File: rtl/clkdiv_sync_chan.sv
module clkdiv_sync_chan
  import clkdiv_sync_pkg::*;
#(
  parameter int DIVW = 8
) (
  input  logic            clk_i,
  input  logic            rst_n_i,
  input  logic            hold_i,
  input  logic            restart_i,
  input  logic            excl_i,
  input  logic [DIVW-1:0] div_i,
  input  logic [DIVW-1:0] phase_i,
  output logic            clk_o
);

  logic [DIVW-1:0] cnt_q;
  logic            out_q;
  logic            held;
  logic            tick;

  assign held = hold_i && !excl_i;
  assign tick = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (held) begin
      cnt_q <= phase_i;
      out_q <= 1'b0;
    end else begin
      cnt_q <= DIVW'(next_count(32'(cnt_q), 32'(div_i)));
      if (tick) out_q <= ~out_q;
    end
  end

  assign clk_o = out_q;

  // R2: a held channel is static low
  assert_hold_static_R2: assert property (
    @(posedge clk_i) disable iff (!rst_n_i)
    held |=> !clk_o);

  // R2: at restart the counter carries the preset phase
  assert_restart_preset_R2: assert property (
    @(posedge clk_i) disable iff (!rst_n_i)
    (restart_i && !excl_i) |-> (cnt_q == phase_i));

  // R1: an excluded channel toggles on every counter wrap, sync or not
  assert_excl_free_R1: assert property (
    @(posedge clk_i) disable iff (!rst_n_i)
    (excl_i && tick) |=> (clk_o != $past(clk_o)));

endmodule

// File: rtl/clkdiv_sync_top.sv
module clkdiv_sync_top #(
  parameter int NCH         = 4,
  parameter int DIVW        = 8,
  parameter int LATENCY     = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              sync_n_i,
  input  logic              pwrdn_n_i,
  input  logic              cal_busy_i,
  input  logic              soft_rst_i,
  input  logic              dist_pd_i,
  input  logic              sh_we_i,
  input  logic              sh_din_i,
  input  logic              update_i,
  input  logic [NCH-1:0]    excl_i,
  input  logic [NCH*DIVW-1:0] div_i,
  input  logic [NCH*DIVW-1:0] phase_i,
  output logic [NCH-1:0]    clk_o
);

  logic req_s;
  logic hold;
  logic restart;

  clkdiv_sync_req #(.SYNC_STAGES(SYNC_STAGES)) u_req (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .sync_n_i   (sync_n_i),
    .pwrdn_n_i  (pwrdn_n_i),
    .cal_busy_i (cal_busy_i),
    .soft_rst_i (soft_rst_i),
    .dist_pd_i  (dist_pd_i),
    .sh_we_i    (sh_we_i),
    .sh_din_i   (sh_din_i),
    .update_i   (update_i),
    .req_o      (req_s)
  );

  clkdiv_sync_release #(.LATENCY(LATENCY), .SYNC_STAGES(SYNC_STAGES)) u_rel (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_i),
    .req_i     (req_s),
    .hold_o    (hold),
    .restart_o (restart)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    clkdiv_sync_chan #(.DIVW(DIVW)) u_chan (
      .clk_i     (clk_i),
      .rst_n_i   (rst_n_i),
      .hold_i    (hold),
      .restart_i (restart),
      .excl_i    (excl_i[i]),
      .div_i     (div_i[i*DIVW +: DIVW]),
      .phase_i   (phase_i[i*DIVW +: DIVW]),
      .clk_o     (clk_o[i])
    );
  end

endmodule

// File: tb/clkdiv_sync_top_tb.sv
module clkdiv_sync_top_tb;

  localparam int NCH  = 4;
  localparam int DIVW = 8;
  localparam int LAT  = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_n = 1'b1, pwrdn_n = 1'b1, cal_busy = 1'b0;
  logic soft_rst = 1'b0, dist_pd = 1'b0;
  logic sh_we = 1'b0, sh_din = 1'b0, update = 1'b0;
  logic [NCH-1:0] excl = 4'b1000;
  logic [NCH*DIVW-1:0] div_v, phase_v;
  logic [NCH-1:0] clk_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clkdiv_sync_top #(.NCH(NCH), .DIVW(DIVW)) u_dut (
    .clk_i(clk), .rst_n_i(rst_n), .sync_n_i(sync_n), .pwrdn_n_i(pwrdn_n),
    .cal_busy_i(cal_busy), .soft_rst_i(soft_rst), .dist_pd_i(dist_pd),
    .sh_we_i(sh_we), .sh_din_i(sh_din), .update_i(update),
    .excl_i(excl), .div_i(div_v), .phase_i(phase_v), .clk_o(clk_out)
  );

  // vectors: {d0, p0, d1, p1}
  localparam logic [31:0] VEC [4] = '{
    {8'd0, 8'd0, 8'd0, 8'd0},
    {8'd1, 8'd0, 8'd3, 8'd2},
    {8'd2, 8'd3, 8'd1, 8'd0},
    {8'd4, 8'd1, 8'd4, 8'd5}
  };

  int d0, p0, d1, p1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int a, input int b, input int c, input int d);
    d0 = a; p0 = b; d1 = c; p1 = d;
    div_v[7:0]    = 8'(a); phase_v[7:0]   = 8'(b);
    div_v[15:8]   = 8'(c); phase_v[15:8]  = 8'(d);
  endtask

  task automatic set_src(input int which, input logic v);
    case (which)
      0: sync_n   = ~v;
      1: cal_busy = v;
      2: pwrdn_n  = ~v;
      3: soft_rst = v;
      default: dist_pd = v;
    endcase
  endtask

  // counts posedges after the current negedge; first high / first low
  task automatic measure(output int r0, output int r1, output int f0);
    r0 = -1; r1 = -1; f0 = -1;
    for (int k = 1; k <= 48; k++) begin
      @(posedge clk); #1;
      if (r0 < 0 && clk_out[0]) r0 = k;
      else if (r0 >= 0 && f0 < 0 && !clk_out[0]) f0 = k;
      if (r1 < 0 && clk_out[1]) r1 = k;
    end
  endtask

  task automatic toggles(input int ch, input int n, output int t);
    logic prev;
    t = 0;
    @(posedge clk); #1;
    prev = clk_out[ch];
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      if (clk_out[ch] != prev) t++;
      prev = clk_out[ch];
    end
  endtask

  task automatic src_sync(input string req, input int which);
    int r0, r1, f0;
    @(negedge clk); set_src(which, 1'b1);
    repeat (5) @(negedge clk);
    chk({req, " held outputs"}, int'(clk_out[2:0]), 0);
    set_src(which, 1'b0);
    measure(r0, r1, f0);
    chk({req, " first edge ch0"}, r0, LAT + p0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int r0, r1, f0, t;
    div_v = '0; phase_v = '0;
    cfg(1, 2, 1, 2);
    div_v[23:16] = 8'd2; phase_v[23:16] = 8'd1;
    div_v[31:24] = 8'd1; phase_v[31:24] = 8'd0;
    repeat (3) @(negedge clk);
    chk("R8 outputs in reset", int'(clk_out), 0);
    rst_n = 1'b1;
    measure(r0, r1, f0);
    chk("R8 first edge after reset", r0, LAT + p0);

    // vector loop: pin sync, hold checks, release timing
    foreach (VEC[i]) begin
      @(negedge clk);
      cfg(VEC[i][31:24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
      repeat (4) @(negedge clk);
      sync_n = 1'b0;
      repeat (5) @(negedge clk);
      chk("R2 held low", int'(clk_out[2:0]), 0);
      toggles(3, 8, t);
      chk("R1 excluded toggles during hold", t, 4);
      @(negedge clk);
      chk("R4 still held while pin low", int'(clk_out[2:0]), 0);
      sync_n = 1'b1;
      measure(r0, r1, f0);
      chk("R3 ch0 first rise", r0, LAT + p0);
      chk("R3 ch1 first rise", r1, LAT + p1);
      chk("R3 ch0 first fall", f0, LAT + p0 + d0 + 1);
    end

    // R9 abort during countdown
    @(negedge clk); sync_n = 1'b0;
    repeat (5) @(negedge clk); sync_n = 1'b1;
    repeat (6) @(negedge clk); sync_n = 1'b0;
    chk("R9 held during countdown", int'(clk_out[2:0]), 0);
    repeat (4) @(negedge clk);
    chk("R9 held after abort", int'(clk_out[2:0]), 0);
    sync_n = 1'b1;
    measure(r0, r1, f0);
    chk("R9 first edge after second release", r0, LAT + p0);

    src_sync("R5 cal busy", 1);
    src_sync("R6 power-down pin", 2);
    src_sync("R6 soft reset", 3);
    src_sync("R6 dist power-down", 4);

    // R7 soft sync through shadow
    @(negedge clk); sh_we = 1'b1; sh_din = 1'b1;
    @(negedge clk); sh_we = 1'b0;
    repeat (4) @(negedge clk);
    toggles(0, 2 * (d0 + 1), t);
    chk("R7 shadow write alone ignored", t, 2);
    @(negedge clk); update = 1'b1;
    @(negedge clk); update = 1'b0;
    repeat (5) @(negedge clk);
    chk("R7 update sets sync", int'(clk_out[2:0]), 0);
    sh_we = 1'b1; sh_din = 1'b0;
    @(negedge clk); sh_we = 1'b0;
    repeat (10) @(negedge clk);
    chk("R7 shadow clear alone ignored", int'(clk_out[2:0]), 0);
    update = 1'b1;
    @(negedge clk); update = 1'b0;
    // the update was sampled on the edge just passed (edge 1)
    measure(r0, r1, f0);
    chk("R7 release after update", r0 + 1, LAT + 1 + p0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule